// File: doc/BRIEF.md
# String Store Byte Sequencer

This block carries out a store-string-word operation over several cycles. When it is started it works out a byte address from a base operand, which can be forced to zero, and an optional index operand. It takes its byte count either from a short immediate field or from the count field of the fixed-point exception register. It then walks through consecutive registers of a 32-entry register file. From each register it takes only the low 32-bit word and sends its four bytes, most significant first, to a byte-wide memory write port. Each byte goes to the next higher address.

The memory write port is a valid/ready stream. While `mem_valid` is high and `mem_ready` is low, the sequencer keeps `mem_addr` and `mem_wdata` unchanged. A byte counts as transferred only in a cycle where both are high. The sequencer never retracts a byte it has offered.

The register file is read through a plain combinational read port: `rf_raddr` selects the register and `rf_rdata_lo` returns its low word in the same cycle. The sequencer has no register write path, so no register is ever modified. `busy` marks a running operation. `done` is a one-cycle pulse at the end.

Top module: `strstore_seq`

## Requirements
- R1: When `base_sel` is 0 the base operand counts as zero and `base_val` is ignored; otherwise the first byte address is `base_val`.
- R2: With `indexed` = 1, `index_val` is added modulo 2^64 to the base operand to form the first address; with `indexed` = 0, `index_val` is ignored.
- R3: With `indexed` = 0, the byte count is `imm_cnt` (5 bits), except that 0 means 32 bytes.
- R4: With `indexed` = 1, the byte count is the 7-bit field `stat_cnt` (bits 57:63, big-endian numbering, of the exception register), from 0 to 127.
- R5: From each source register's low word the bytes go out in the order [31:24], [23:16], [15:8], [7:0]; a register is left after its fourth byte.
- R6: The first source register is `src_reg`; each following register is the previous one plus one modulo 32, so register 31 is followed by register 0.
- R7: Every byte transferred on the memory port goes to an address one higher than the previous one, modulo 2^64.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values in the next cycle.
- R9: A byte count of zero produces no memory write; `done` rises in the cycle after the start is accepted.
- R10: `done` is high for exactly one cycle after the last byte is transferred. `busy` is high from the cycle after an accepted start until then. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| indexed | input | 1 | 1: indexed form, count from `stat_cnt`; 0: immediate form |
| src_reg | input | 5 | First source register number |
| base_sel | input | 5 | Base register field; 0 forces the base operand to zero |
| base_val | input | 64 | Value of the base register |
| index_val | input | 64 | Value of the index register (indexed form only) |
| imm_cnt | input | 5 | Immediate byte count, 0 meaning 32 |
| stat_cnt | input | 7 | Byte-count field of the exception register |
| rf_raddr | output | 5 | Register file read address |
| rf_rdata_lo | input | 32 | Low word of the addressed register |
| mem_valid | output | 1 | A byte is offered on the memory port |
| mem_ready | input | 1 | Memory accepts the offered byte |
| mem_addr | output | 64 | Byte address of the offered byte |
| mem_wdata | output | 8 | Offered byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A short immediate store from a zero base with `mem_ready` always high separates correct byte order and address stepping from lane or address slips. An immediate count of zero starting at register 30 runs 32 bytes across the 31-to-0 wrap under an irregular ready pattern. That run tells correct register wrap and stall holding apart from sequencers that drop or repeat bytes under back-pressure. Indexed runs with a full 127-byte count, a zero count and an address near 2^64 separate correct index addition, count-field decode and address wrap from wrong ones. An immediate run with a nonzero index value, and a second start issued mid-operation, show that the ignored inputs leave the byte stream unchanged.

// File: rtl/strstore_pkg.sv
package strstore_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_SEND = 2'd2,
    SQ_DONE = 2'd3
  } sq_state_t;
endpackage

// File: rtl/strstore_count_dec.sv
module strstore_count_dec #(
  parameter int IMM_W = 5,
  parameter int CNT_W = 7
) (
  input  logic             indexed,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] stat_cnt,
  output logic [CNT_W-1:0] byte_cnt
);
  localparam logic [CNT_W-1:0] IMM_FULL = CNT_W'(1 << IMM_W);

  always_comb begin
    if (indexed)
      byte_cnt = stat_cnt;
    else if (imm_cnt == '0)
      byte_cnt = IMM_FULL;
    else
      byte_cnt = CNT_W'(imm_cnt);
  end

  // R3: the immediate form can never ask for zero bytes
  always_comb begin
    if (!indexed) begin
      p_imm_nonzero_r3: assert (byte_cnt != '0);
    end
  end
endmodule

// File: rtl/strstore_ea_gen.sv
module strstore_ea_gen #(
  parameter int ADDR_W = 64,
  parameter int RIDX_W = 5
) (
  input  logic              indexed,
  input  logic [RIDX_W-1:0] base_sel,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] base_op;
  logic [ADDR_W-1:0] index_op;

  assign base_op  = (base_sel == '0) ? '0 : base_val;
  assign index_op = indexed ? index_val : '0;
  assign ea       = base_op + index_op;
endmodule

// File: rtl/strstore_lane_pick.sv
module strstore_lane_pick #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  output logic [BYTE_W-1:0] byte_out
);
  logic [BYTE_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word[WORD_W-1-g*BYTE_W -: BYTE_W];
  end

  assign byte_out = lane_bytes[lane];
endmodule

// File: rtl/strstore_seq.sv
module strstore_seq
  import strstore_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int ADDR_W = 64,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int IMM_W  = 5,
  parameter int CNT_W  = 7,
  localparam int RIDX_W = $clog2(NREG),
  localparam int WORD_W = BYTE_W * LANES,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              indexed,
  input  logic [RIDX_W-1:0] src_reg,
  input  logic [RIDX_W-1:0] base_sel,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [IMM_W-1:0]  imm_cnt,
  input  logic [CNT_W-1:0]  stat_cnt,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [WORD_W-1:0] rf_rdata_lo,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  localparam logic [RIDX_W-1:0] LAST_REG  = RIDX_W'(NREG - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  sq_state_t         state_q;
  logic [RIDX_W-1:0] reg_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q;

  logic [CNT_W-1:0]  dec_cnt;
  logic [ADDR_W-1:0] dec_ea;
  logic              accept;
  logic              xfer;

  strstore_count_dec #(.IMM_W(IMM_W), .CNT_W(CNT_W)) i_count_dec (
    .indexed  (indexed),
    .imm_cnt  (imm_cnt),
    .stat_cnt (stat_cnt),
    .byte_cnt (dec_cnt)
  );

  strstore_ea_gen #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) i_ea_gen (
    .indexed   (indexed),
    .base_sel  (base_sel),
    .base_val  (base_val),
    .index_val (index_val),
    .ea        (dec_ea)
  );

  strstore_lane_pick #(.BYTE_W(BYTE_W), .LANES(LANES)) i_lane_pick (
    .word     (word_q),
    .lane     (lane_q),
    .byte_out (mem_wdata)
  );

  assign accept    = start && (state_q == SQ_IDLE);
  assign xfer      = (state_q == SQ_SEND) && mem_ready;
  assign mem_valid = (state_q == SQ_SEND);
  assign mem_addr  = addr_q;
  assign rf_raddr  = reg_q;
  assign busy      = (state_q == SQ_LOAD) || (state_q == SQ_SEND);
  assign done      = (state_q == SQ_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      reg_q   <= '0;
      lane_q  <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      word_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (accept) begin
            addr_q  <= dec_ea;
            cnt_q   <= dec_cnt;
            reg_q   <= src_reg;
            lane_q  <= '0;
            state_q <= (dec_cnt == '0) ? SQ_DONE : SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          word_q  <= rf_rdata_lo;
          state_q <= SQ_SEND;
        end
        SQ_SEND: begin
          if (xfer) begin
            addr_q <= addr_q + ADDR_W'(1);
            cnt_q  <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
              state_q <= SQ_DONE;
            end else if (lane_q == LAST_LANE) begin
              lane_q  <= '0;
              reg_q   <= (reg_q == LAST_REG) ? '0 : reg_q + RIDX_W'(1);
              state_q <= SQ_LOAD;
            end else begin
              lane_q <= lane_q + LANE_W'(1);
            end
          end
        end
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a stalled byte is held steady
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

  // R7: each accepted byte advances the address by one
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R9: no write offered outside an operation
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  // R9: a zero count accepted when idle ends in the next cycle
  p_zero_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && indexed && stat_cnt == '0) |=> done);

  // R6: the source register only moves after the last lane was taken
  p_reg_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !(mem_ready && lane_q == LAST_LANE)) |=> $stable(rf_raddr));
endmodule

// File: tb/test_strstore_seq.sv
`timescale 1ns/100ps
module test_strstore_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        indexed = 1'b0;
  logic [4:0]  src_reg = '0;
  logic [4:0]  base_sel = '0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [4:0]  imm_cnt = 5'd1;
  logic [6:0]  stat_cnt = '0;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata_lo;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic        done;

  typedef struct packed { logic [63:0] addr; logic [7:0] data; } item_t;
  item_t exp_q[$];

  int    n_checks = 0;
  int    n_fail = 0;
  int    n_writes = 0;
  bit    rand_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_tag = "R0";
  logic [31:0] rf [32];

  always #2.5 clk = ~clk;

  assign rf_rdata_lo = rf[rf_raddr];

  strstore_seq i_strstore_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed),
    .src_reg(src_reg), .base_sel(base_sel), .base_val(base_val),
    .index_val(index_val), .imm_cnt(imm_cnt), .stat_cnt(stat_cnt),
    .rf_raddr(rf_raddr), .rf_rdata_lo(rf_rdata_lo), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: set ready, then evaluate the handshake of the coming edge
  logic        prev_stall = 1'b0;
  logic [63:0] prev_addr = '0;
  logic [7:0]  prev_data = '0;
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = rand_ready ? lfsr[0] : 1'b1;
      #0.1;
      if (prev_stall) begin
        check({"R8 hold ", cur_tag}, {mem_valid, mem_addr[54:0], mem_wdata},
              {1'b1, prev_addr[54:0], prev_data});
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_data  = mem_wdata;
      if (mem_valid && mem_ready) begin
        n_writes++;
        if (exp_q.size() == 0) begin
          check({"R10 unexpected write ", cur_tag}, 64'd1, 64'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check({"R7 addr ", cur_tag}, mem_addr, it.addr);
          check({"R5 data ", cur_tag}, {56'd0, mem_wdata}, {56'd0, it.data});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_op(input string tag, input bit idx, input logic [4:0] src,
                        input logic [4:0] bsel, input logic [63:0] bval,
                        input logic [63:0] ival, input logic [4:0] imm,
                        input logic [6:0] scnt, input bit poke);
    logic [63:0] ea;
    int n;
    int r;
    int lane;
    int w0;
    int k;
    @(negedge clk);
    cur_tag = tag;
    indexed = idx; src_reg = src; base_sel = bsel; base_val = bval;
    index_val = ival; imm_cnt = imm; stat_cnt = scnt;
    ea = ((bsel == 0) ? 64'd0 : bval) + (idx ? ival : 64'd0);
    n  = idx ? int'(scnt) : ((imm == 0) ? 32 : int'(imm));
    r = int'(src);
    lane = 0;
    for (int j = 0; j < n; j++) begin
      item_t it;
      it.addr = ea + 64'(j);
      it.data = rf[r][31-8*lane -: 8];
      exp_q.push_back(it);
      lane++;
      if (lane == 4) begin lane = 0; r = (r + 1) % 32; end
    end
    w0 = n_writes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check({"R9 done next cycle ", tag}, {63'd0, done}, 64'd1);
      check({"R9 not busy ", tag}, {63'd0, busy}, 64'd0);
    end else begin
      check({"R10 busy after start ", tag}, {62'd0, busy, done}, 64'd2);
      if (poke) begin
        repeat (3) @(negedge clk);
        indexed = 1'b0; src_reg = 5'd9; base_sel = 5'd1; base_val = 64'h5000;
        imm_cnt = 5'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      k = 0;
      while (!done && k < 4000) begin @(negedge clk); k++; end
      check({"R10 done seen ", tag}, {63'd0, done}, 64'd1);
      check({"R10 not busy at done ", tag}, {63'd0, busy}, 64'd0);
    end
    @(negedge clk);
    check({"R10 done one cycle ", tag}, {63'd0, done}, 64'd0);
    repeat (3) @(negedge clk);
    check({"count ", tag}, 64'(n_writes - w0), 64'(n));
    check({"queue drained ", tag}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf[i] = {8'(8'h10 + i), 8'(8'h40 + i), 8'(8'h80 + i), 8'(8'hC0 + i)};
    end
    repeat (3) @(negedge clk);
    check("R10 reset busy", {63'd0, busy}, 64'd0);
    check("R10 reset done", {63'd0, done}, 64'd0);
    check("R9 reset no write", {63'd0, mem_valid}, 64'd0);
    rst_n = 1'b1;
    // R1: zero base field ignores base_val; R3 short immediate count
    run_op("R1_R3 imm7", 1'b0, 5'd3, 5'd0, 64'hDEAD_0000, 64'd0, 5'd7, 7'd0, 1'b0);
    // R1: nonzero base field uses base_val
    run_op("R1 base", 1'b0, 5'd12, 5'd6, 64'h0000_1234_5678_0000, 64'd0, 5'd5, 7'd0, 1'b0);
    rand_ready = 1'b1;
    // R3 zero immediate = 32 bytes, R6 register wrap 31->0, R8 stalls
    run_op("R3_R6 imm0 wrap", 1'b0, 5'd30, 5'd2, 64'h800, 64'd0, 5'd0, 7'd0, 1'b0);
    // R2 immediate form ignores index_val
    run_op("R2 ignore index", 1'b0, 5'd1, 5'd3, 64'h100, 64'hFFFF_0000, 5'd6, 7'd9, 1'b0);
    // R2 index added, R4 full 7-bit count with wrap
    run_op("R2_R4 idx127", 1'b1, 5'd7, 5'd4, 64'h2000, 64'h35, 5'd3, 7'd127, 1'b0);
    // R7 address wrap past 2^64
    run_op("R7 addr wrap", 1'b1, 5'd31, 5'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFD, 5'd0, 7'd6, 1'b0);
    // R9 zero indexed count
    run_op("R9 zero", 1'b1, 5'd5, 5'd1, 64'h40, 64'h8, 5'd4, 7'd0, 1'b0);
    // R10 start while busy ignored
    run_op("R10 poke", 1'b1, 5'd20, 5'd8, 64'h3000, 64'h1, 5'd0, 7'd23, 1'b1);
    finish_run();
  end
endmodule